// File: doc/BRIEF.md
# I2C Target Controller with Clock Stretching

This block is a bus target (slave) for a two-wire serial bus. It sits beside a CPU. The block samples SCL and SDA through synchronizers and finds start, repeated start and stop conditions. It shifts in address and data bytes, and it shifts out transmit bytes. When an event needs software, the block sets a status bit and holds SCL low. The bus stays frozen until the CPU clears that bit. Each acknowledge the block gives is decided by a software control bit, not by the hardware.

The CPU uses a small register file with six locations: status, interrupt mask, acknowledge control, address configuration, received data and transmit data. The block supports 7-bit addressing, 10-bit addressing and the general call address. It drops start-byte transactions without any response. One level interrupt reports the status bits that the mask lets through. Both bus lines are open-drain: each has an input sample and an output enable that pulls the line low.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: SCL is pulled low while any of these status bits is set: addressed (bit 0), write request (bit 1) or read request (bit 2). SCL is released only after the CPU has cleared all three.
- R2: `irq` is high exactly when some status bit is set whose bit in the mask register (offset 1, a 1 masks the bit) is 0.
- R3: In the acknowledge phase after a byte the block has accepted, SDA is pulled low if the acknowledge control bit (offset 2, bit 0) is 1. Otherwise SDA stays released, which is a NACK. After a NACK the block ignores the bus until the next start condition.
- R4: The address configuration register is at offset 3. Bits 9:0 hold the address, bit 10 selects 10-bit mode and bit 11 enables general call.
  - In 7-bit mode, byte[7:1] is compared with address[6:0].
  - In 10-bit mode, a header byte `11110`+address[9:8]+`0` is acknowledged as set by R3, without stretching. A second byte equal to address[7:0] then addresses the block.
  - In 10-bit mode, a byte that only matches the low seven address bits is ignored.
- R5: The byte 0x00 with general call enabled sets both the addressed bit and the general call bit (status bit 3). With general call disabled, 0x00 gets no response.
- R6: On an address match the addressed bit is set. The received-data register (offset 4) holds the whole address byte, including the R/W bit.
- R7: A start byte (0x01) sets no status bit and gets no acknowledge. The block then evaluates the address that follows the next repeated start.
- R8: After each data byte received from the master, the byte appears in the received-data register and the write request bit is set.
- R9: In a read, the read request bit is set after the acknowledge of the address and after each master ACK. Once the CPU clears it, the byte in the transmit-data register (offset 5) is sent MSB first. A master NACK ends the transfer: no further request is made and SDA is released.
- R10: After reset, status is 0, both lines are released and `irq` is low. Writing a 1 to a status bit clears it. Status bits written with 0 keep their value.
- R11: After a 10-bit address match, a repeated start with header R/W = 1 (`11110`+address[9:8]+`1`) is acknowledged and is followed by a read request.
- R12: An address that does not match gives no status bit, no acknowledge and no stretching.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for the addressed offset |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| irq | output | 1 | Level interrupt |

## Verification
The embedded properties assume the following about the bus and the CPU:
- The CPU changes the acknowledge control and transmit-data registers only while SCL is low: either while the block stretches SCL, or while the bus is idle.
- The master changes SDA only while SCL is low, except when it makes a start or a stop.
- Every SCL phase lasts longer than the synchronizer latency.

The directed bench keeps each SCL phase at eight system clocks. It writes the acknowledge and transmit registers only between transfers or while SCL is held low by stretching. It releases its own SDA drive in every phase where the target may answer.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   localparam int STS_W = 4;
   localparam int B_ADR = 0;
   localparam int B_RXR = 1;
   localparam int B_TXR = 2;
   localparam int B_GC  = 3;

   localparam int RA_STATUS = 0;
   localparam int RA_MASK   = 1;
   localparam int RA_ACK    = 2;
   localparam int RA_CFG    = 3;
   localparam int RA_RXD    = 4;
   localparam int RA_TXD    = 5;

   typedef enum logic [2:0] {
      PH_IDLE, PH_ADDR, PH_ADDR2, PH_ACK, PH_RX, PH_TX, PH_MACK, PH_WAIT
   } phase_t;

   typedef enum logic [1:0] {NX_RX, NX_TX, NX_ADDR2} after_t;

   typedef struct packed {
      logic [9:0] addr;
      logic       ten;
      logic       gce;
   } cfg_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   localparam int LINES = 2;

   if (STAGES < 2) begin : g_bad_stages
      $error("synchronizer needs at least two stages");
   end

   logic [LINES-1:0] raw, synced;
   logic             scl_p, sda_p;

   assign raw = {sda_i, scl_i};

   for (genvar l = 0; l < LINES; l++) begin : g_line
      logic [STAGES-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '1;
         else        q <= {q[STAGES-2:0], raw[l]};
      end
      assign synced[l] = q[STAGES-1];
   end

   assign scl_s = synced[0];
   assign sda_s = synced[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign start_det = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
   import i2c_tgt_pkg::*;
#(
   parameter int RAW = 3,
   parameter int RDW = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [RAW-1:0]   reg_addr,
   input  logic             reg_we,
   input  logic [RDW-1:0]   reg_wdata,
   output logic [RDW-1:0]   reg_rdata,
   input  logic [STS_W-1:0] set_sts,
   input  logic             rx_load,
   input  logic [7:0]       rx_byte,
   output logic [STS_W-1:0] sts,
   output logic             ack_en,
   output cfg_t             cfg,
   output logic [7:0]       tx_byte,
   output logic             irq
);
   logic [STS_W-1:0] mask, clr;
   logic [7:0]       rxd;
   logic             unused_wdata;

   assign unused_wdata = ^reg_wdata[RDW-1:12];
   assign clr = (reg_we && int'(reg_addr) == RA_STATUS) ? reg_wdata[STS_W-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts     <= '0;
         mask    <= '0;
         ack_en  <= 1'b0;
         cfg     <= '0;
         rxd     <= '0;
         tx_byte <= '0;
      end else begin
         sts <= (sts & ~clr) | set_sts;
         if (rx_load) rxd <= rx_byte;
         if (reg_we) begin
            case (int'(reg_addr))
               RA_MASK: mask    <= reg_wdata[STS_W-1:0];
               RA_ACK:  ack_en  <= reg_wdata[0];
               RA_CFG:  cfg     <= '{addr: reg_wdata[9:0], ten: reg_wdata[10], gce: reg_wdata[11]};
               RA_TXD:  tx_byte <= reg_wdata[7:0];
               default: ;
            endcase
         end
      end
   end

   assign irq = |(sts & ~mask);

   always_comb begin
      reg_rdata = '0;
      case (int'(reg_addr))
         RA_STATUS: reg_rdata[STS_W-1:0] = sts;
         RA_MASK:   reg_rdata[STS_W-1:0] = mask;
         RA_ACK:    reg_rdata[0]         = ack_en;
         RA_CFG:    reg_rdata[11:0]      = {cfg.gce, cfg.ten, cfg.addr};
         RA_RXD:    reg_rdata[7:0]       = rxd;
         RA_TXD:    reg_rdata[7:0]       = tx_byte;
         default:   ;
      endcase
   end

   assert_irq_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(|set_sts) || $past(reg_we && int'(reg_addr) == RA_MASK)));

   assert_gc_with_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts[B_GC]) |-> sts[B_ADR]);
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
   import i2c_tgt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_s,
   input  logic             sda_s,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_det,
   input  logic             stop_det,
   input  cfg_t             cfg,
   input  logic             ack_en,
   input  logic [7:0]       tx_byte,
   input  logic             adr_pend,
   input  logic             txr_pend,
   output logic [STS_W-1:0] set_sts,
   output logic             rx_load,
   output logic [7:0]       rx_byte,
   output logic             sda_oe
);
   localparam logic [3:0] BITS = 4'd8;

   phase_t     ph;
   after_t     nx;
   logic [3:0] cnt;
   logic [7:0] sh, txb;
   logic       ten_sel, ack_got, mack;
   logic [6:0] hdr7;

   assign hdr7    = {5'b11110, cfg.addr[9:8]};
   assign rx_byte = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph <= PH_IDLE; nx <= NX_RX; cnt <= '0; sh <= '0; txb <= '1;
         ten_sel <= 1'b0; ack_got <= 1'b0; mack <= 1'b0;
         set_sts <= '0; rx_load <= 1'b0;
      end else begin
         set_sts <= '0;
         rx_load <= 1'b0;
         if (txr_pend) txb <= tx_byte;
         if (stop_det) begin
            ph      <= PH_IDLE;
            ten_sel <= 1'b0;
         end else if (start_det) begin
            ph  <= PH_ADDR;
            cnt <= '0;
         end else begin
            if (scl_rise) begin
               sh      <= {sh[6:0], sda_s};
               ack_got <= ack_en;
               mack    <= ~sda_s;
               if (cnt != BITS) cnt <= cnt + 4'd1;
            end
            if (scl_fall) begin
               case (ph)
                  PH_ADDR: if (cnt == BITS) begin
                     cnt <= '0;
                     if (sh == 8'h01) begin
                        ph <= PH_WAIT;
                     end else if (sh == 8'h00 && cfg.gce) begin
                        set_sts[B_ADR] <= 1'b1; set_sts[B_GC] <= 1'b1;
                        rx_load <= 1'b1; ten_sel <= 1'b0; nx <= NX_RX; ph <= PH_ACK;
                     end else if (cfg.ten && sh[7:1] == hdr7) begin
                        if (!sh[0]) begin
                           nx <= NX_ADDR2; ph <= PH_ACK;
                        end else if (ten_sel) begin
                           rx_load <= 1'b1; nx <= NX_TX; ph <= PH_ACK;
                        end else begin
                           ph <= PH_WAIT;
                        end
                     end else if (!cfg.ten && sh[7:1] == cfg.addr[6:0]) begin
                        set_sts[B_ADR] <= 1'b1; rx_load <= 1'b1;
                        nx <= sh[0] ? NX_TX : NX_RX; ph <= PH_ACK;
                     end else begin
                        ph <= PH_WAIT;
                     end
                  end
                  PH_ADDR2: if (cnt == BITS) begin
                     cnt <= '0;
                     if (sh == cfg.addr[7:0]) begin
                        set_sts[B_ADR] <= 1'b1; rx_load <= 1'b1;
                        ten_sel <= 1'b1; nx <= NX_RX; ph <= PH_ACK;
                     end else begin
                        ten_sel <= 1'b0; ph <= PH_WAIT;
                     end
                  end
                  PH_RX: if (cnt == BITS) begin
                     cnt <= '0;
                     set_sts[B_RXR] <= 1'b1; rx_load <= 1'b1;
                     nx <= NX_RX; ph <= PH_ACK;
                  end
                  PH_ACK: begin
                     cnt <= '0;
                     if (!ack_got) ph <= PH_WAIT;
                     else begin
                        case (nx)
                           NX_ADDR2: ph <= PH_ADDR2;
                           NX_TX:    begin ph <= PH_TX; set_sts[B_TXR] <= 1'b1; end
                           default:  ph <= PH_RX;
                        endcase
                     end
                  end
                  PH_TX: begin
                     txb <= {txb[6:0], 1'b1};
                     if (cnt == BITS) begin cnt <= '0; ph <= PH_MACK; end
                  end
                  PH_MACK: begin
                     cnt <= '0;
                     if (mack) begin ph <= PH_TX; set_sts[B_TXR] <= 1'b1; end
                     else ph <= PH_WAIT;
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   always_comb begin
      case (ph)
         PH_ACK:  sda_oe = ack_en;
         PH_TX:   sda_oe = ~txb[7];
         default: sda_oe = 1'b0;
      endcase
   end

   assert_sda_moves_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);

   assert_addr_in_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adr_pend) |-> ph == PH_ACK);

   assert_txreq_in_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(txr_pend) |-> ph == PH_TX);
endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch
   import i2c_tgt_pkg::*;
#(
   parameter int RAW         = 3,
   parameter int RDW         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [RAW-1:0] reg_addr,
   input  logic           reg_we,
   input  logic [RDW-1:0] reg_wdata,
   output logic [RDW-1:0] reg_rdata,
   input  logic           scl_i,
   input  logic           sda_i,
   output logic           scl_oe,
   output logic           sda_oe,
   output logic           irq
);
   if (RAW < 3) begin : g_bad_raw
      $error("register offset width must cover six registers");
   end
   if (RDW < 12) begin : g_bad_rdw
      $error("register data width must hold the address configuration");
   end

   logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [STS_W-1:0] set_sts, sts;
   logic             rx_load, ack_en;
   logic [7:0]       rx_byte, tx_byte;
   cfg_t             cfg;

   i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   i2c_tgt_regs #(.RAW(RAW), .RDW(RDW)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .set_sts(set_sts),
      .rx_load(rx_load), .rx_byte(rx_byte), .sts(sts), .ack_en(ack_en),
      .cfg(cfg), .tx_byte(tx_byte), .irq(irq)
   );

   i2c_tgt_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
      .stop_det(stop_det), .cfg(cfg), .ack_en(ack_en), .tx_byte(tx_byte),
      .adr_pend(sts[B_ADR]), .txr_pend(sts[B_TXR]), .set_sts(set_sts),
      .rx_load(rx_load), .rx_byte(rx_byte), .sda_oe(sda_oe)
   );

   assign scl_oe = |sts[B_TXR:B_ADR];

   assert_release_by_cpu_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl_oe) |-> $past(reg_we && int'(reg_addr) == RA_STATUS));
endmodule

// File: tb/i2c_tgt_stretch_bench.sv
module i2c_tgt_stretch_bench;
   localparam int Q = 8;
   localparam logic [2:0] A_STS = 3'd0, A_MSK = 3'd1, A_ACK = 3'd2,
                          A_CFG = 3'd3, A_RXD = 3'd4, A_TXD = 3'd5;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic [2:0]  ra = '0;
   logic        we = 1'b0;
   logic [15:0] wd = '0;
   wire  [15:0] rd;
   logic        scl_m = 1'b1, sda_m = 1'b1;
   wire         scl_oe, sda_oe, irq;
   wire         scl_line = scl_m & ~scl_oe;
   wire         sda_line = sda_m & ~sda_oe;
   int          n_chk = 0, n_bad = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   i2c_tgt_stretch u_i2c_tgt_stretch (
      .clk(clk), .rst_n(rst_n), .reg_addr(ra), .reg_we(we), .reg_wdata(wd),
      .reg_rdata(rd), .scl_i(scl_line), .sda_i(sda_line),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic hold(input int n); repeat (n) @(negedge clk); endtask
   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk); ra = a; wd = d; we = 1'b1;
      @(negedge clk); we = 1'b0;
   endtask
   task automatic rdv(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk); ra = a; #1 d = rd;
   endtask

   task automatic m_start;  sda_m = 1; scl_m = 1; hold(Q); sda_m = 0; hold(Q); scl_m = 0; hold(Q); endtask
   task automatic m_rstart; sda_m = 1; hold(Q); scl_m = 1; hold(Q); sda_m = 0; hold(Q); scl_m = 0; hold(Q); endtask
   task automatic m_stop;   sda_m = 0; hold(Q); scl_m = 1; hold(Q); sda_m = 1; hold(Q); endtask
   task automatic m_clk(input logic b, output logic s);
      sda_m = b; hold(Q); scl_m = 1;
      while (!scl_line) @(negedge clk);
      hold(Q/2); s = sda_line; hold(Q/2); scl_m = 0; hold(Q);
   endtask
   task automatic m_byte(input logic [7:0] b);
      logic s;
      for (int i = 7; i >= 0; i--) m_clk(b[i], s);
   endtask
   task automatic m_rbyte(output logic [7:0] v);
      logic s;
      for (int i = 7; i >= 0; i--) begin m_clk(1'b1, s); v[i] = s; end
   endtask
   task automatic ack_clk(input string req, input logic exp_ack);
      logic s;
      m_clk(1'b1, s);
      chk(req, !s, exp_ack);
   endtask
   task automatic see(input string req, input logic [2:0] a, input logic [15:0] exp);
      logic [15:0] v;
      rdv(a, v); chk(req, v, exp);
   endtask

   task automatic t_reset;
      see("R10 status after reset", A_STS, 16'h0);
      chk("R10 irq after reset", irq, 0);
      chk("R10 scl released", scl_oe, 0);
      chk("R10 sda released", sda_oe, 0);
   endtask

   task automatic t_write7;
      wr(A_CFG, 16'h002A); wr(A_ACK, 1); wr(A_MSK, 0);
      m_start; m_byte(8'h54); hold(4);
      see("R6 addressed bit", A_STS, 16'h1);
      see("R6 address byte", A_RXD, 16'h54);
      chk("R2 irq unmasked", irq, 1);
      sda_m = 1; hold(Q); scl_m = 1; hold(30);
      chk("R1 scl held low", scl_line, 0);
      wr(A_STS, 16'h1); hold(4);
      chk("R1 scl released", scl_line, 1);
      chk("R3 ack driven", sda_line, 0);
      hold(Q/2); scl_m = 0; hold(Q);
      see("R10 w1c cleared", A_STS, 16'h0);
      m_byte(8'hA5); hold(4);
      see("R8 write request", A_STS, 16'h2);
      see("R8 data byte", A_RXD, 16'hA5);
      wr(A_STS, 16'h0);
      see("R10 zero write keeps bit", A_STS, 16'h2);
      wr(A_STS, 16'h2);
      ack_clk("R3 ack on data", 1);
      wr(A_ACK, 0);
      m_byte(8'h3C); hold(4);
      see("R8 second data byte", A_RXD, 16'h3C);
      wr(A_STS, 16'h2);
      ack_clk("R3 nack when control clear", 0);
      m_stop;
      chk("R1 idle after stop", scl_oe, 0);
      wr(A_ACK, 1);
   endtask

   task automatic t_mask;
      wr(A_MSK, 16'h1);
      m_start; m_byte(8'h54); hold(4);
      chk("R2 masked irq low", irq, 0);
      see("R2 status still set", A_STS, 16'h1);
      wr(A_MSK, 16'hE);
      chk("R2 unmasked irq high", irq, 1);
      wr(A_STS, 16'h1);
      chk("R2 irq low after clear", irq, 0);
      ack_clk("R3 ack", 1);
      m_stop; wr(A_MSK, 0);
   endtask

   task automatic t_read7;
      logic [7:0] v; logic s;
      m_start; m_byte(8'h55); hold(4);
      see("R6 read address byte", A_RXD, 16'h55);
      wr(A_STS, 16'h1);
      ack_clk("R3 ack read address", 1);
      hold(4);
      see("R9 read request", A_STS, 16'h4);
      chk("R1 stretch for read", scl_oe, 1);
      wr(A_TXD, 16'hC3); wr(A_STS, 16'h4);
      m_rbyte(v); chk("R9 first byte", v, 8'hC3);
      m_clk(1'b0, s); hold(4);
      see("R9 request after master ack", A_STS, 16'h4);
      wr(A_TXD, 16'h5A); wr(A_STS, 16'h4);
      m_rbyte(v); chk("R9 second byte", v, 8'h5A);
      m_clk(1'b1, s); hold(4);
      see("R9 no request after nack", A_STS, 16'h0);
      chk("R9 sda released after nack", sda_oe, 0);
      m_stop;
   endtask

   task automatic t_nomatch;
      m_start; m_byte(8'h40); hold(4);
      see("R12 no status", A_STS, 16'h0);
      chk("R12 no stretch", scl_oe, 0);
      ack_clk("R12 no ack", 0);
      m_stop;
   endtask

   task automatic t_startbyte;
      wr(A_CFG, 16'h082A);
      m_start; m_byte(8'h01); hold(4);
      see("R7 start byte no status", A_STS, 16'h0);
      ack_clk("R7 start byte no ack", 0);
      m_rstart; m_byte(8'h54); hold(4);
      see("R7 address after restart", A_STS, 16'h1);
      wr(A_STS, 16'h1);
      ack_clk("R7 ack after restart", 1);
      m_stop;
   endtask

   task automatic t_gcall;
      wr(A_CFG, 16'h082A);
      m_start; m_byte(8'h00); hold(4);
      see("R5 general call bits", A_STS, 16'h9);
      see("R5 general call byte", A_RXD, 16'h00);
      wr(A_STS, 16'h9);
      ack_clk("R5 general call ack", 1);
      m_stop;
      wr(A_CFG, 16'h002A);
      m_start; m_byte(8'h00); hold(4);
      see("R5 disabled general call", A_STS, 16'h0);
      ack_clk("R5 disabled no ack", 0);
      m_stop;
   endtask

   task automatic t_ten;
      logic [7:0] v; logic s;
      wr(A_CFG, 16'h06C7);
      m_start; m_byte(8'h8E); hold(4);
      see("R4 low bits ignored in 10-bit mode", A_STS, 16'h0);
      ack_clk("R4 no ack for 7-bit form", 0);
      m_stop;
      m_start; m_byte(8'hF4); ack_clk("R4 header ack", 1);
      m_byte(8'hC6); hold(4);
      see("R4 wrong low byte", A_STS, 16'h0);
      ack_clk("R4 wrong low byte nack", 0);
      m_stop;
      m_start; m_byte(8'hF4); hold(4);
      chk("R4 header without stretch", scl_oe, 0);
      see("R4 header no status", A_STS, 16'h0);
      ack_clk("R4 header ack", 1);
      m_byte(8'hC7); hold(4);
      see("R4 10-bit addressed", A_STS, 16'h1);
      see("R6 second address byte", A_RXD, 16'hC7);
      wr(A_STS, 16'h1); ack_clk("R3 ack 10-bit", 1);
      m_byte(8'h11); hold(4);
      see("R8 10-bit data", A_STS, 16'h2);
      wr(A_STS, 16'h2); ack_clk("R3 ack 10-bit data", 1);
      m_rstart; m_byte(8'hF5); hold(4);
      see("R11 read header no addressed bit", A_STS, 16'h0);
      ack_clk("R11 read header ack", 1);
      hold(4);
      see("R11 read request", A_STS, 16'h4);
      wr(A_TXD, 16'h96); wr(A_STS, 16'h4);
      m_rbyte(v); chk("R11 read byte", v, 8'h96);
      m_clk(1'b1, s);
      m_stop;
   endtask

   initial begin
      hold(5); rst_n = 1'b1; hold(3);
      t_reset;
      t_write7;
      t_mask;
      t_read7;
      t_nomatch;
      t_startbyte;
      t_gcall;
      t_ten;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule